// File: doc/BRIEF.md
# Selectable Fast Interrupt Router

This block takes eight peripheral interrupt request lines and routes one of them, chosen by software, to a single active-low fast-interrupt line for the CPU. A rising edge on the chosen line sets a sticky pending flag. The flag stays set until software writes a 1 to clear it. A global enable bit decides whether a pending request actually pulls the fast line low.

The routed source is taken out of the normal interrupt path: its node output is held at 0, and the other seven lines pass through unchanged. Software reaches the block through a small register port with two registers: a control register (enable and select) and a pending register. Writes to either register are accepted only while an external standby unlock flag is high.

Top module: `fast_irq_router`

## Requirements
- R1: The control field sel (bits [2:0] at address 0) picks the routed source. A 0-to-1 transition of that source, seen between two consecutive clock edges, sets the pending flag at the next edge.
- R2: Once set, the pending flag stays set. Writing data bit 0 = 1 to address 1 clears it at the next edge. Writing bit 0 = 0 leaves it unchanged.
- R3: Reads are combinational. Address 0 returns {en, 4'b0000, sel}, with en at bit 7. Address 1 returns {7'b0, pending}.
- R4: fast_irq_no is 0 exactly when the pending flag and en are both 1. Otherwise it is 1.
- R5: If a set event and a clear write fall in the same cycle, the pending flag ends up set.
- R6: node_o[sel] is 0. Every other node_o[i] equals src_i[i] in the same cycle.
- R7: While unlock_i is 0, writes to either address change nothing.
- R8: After reset, en, sel and the pending flag are all 0, so fast_irq_no is 1.
- R9: Writing a new sel value does not clear a pending flag.
- R10: A source that stays high sets the flag only once. After a clear, the flag stays 0 until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Peripheral interrupt requests, active high |
| unlock_i | input | 1 | Standby unlock flag; register writes are enabled while it is high |
| addr_i | input | 1 | Register select: 0 = control, 1 = pending |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| fast_irq_no | output | 1 | Fast interrupt to the CPU, active low |
| node_o | output | 8 | Interrupt node outputs, with the routed source masked |

## Verification
The bench targets a clear write and a set event arriving in the same cycle: a design that lets the clear win would lose that interrupt. It holds a source high across a clear, where a level-sensitive design would set the flag again at once. It changes the select while the flag is pending, where a careless design would clear the flag or re-route it. It also sends writes while the unlock flag is low, where a design missing the gate would change its enable or drop a pending request.

// File: rtl/fast_irq_pkg.sv
package fast_irq_pkg;
  parameter int unsigned NUM_SRC = 8;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned EN_BIT  = 7;
  localparam int unsigned SEL_W  = $clog2(NUM_SRC);
endpackage

// File: rtl/fir_ctrl_reg.sv
module fir_ctrl_reg
  import fast_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned ENB   = EN_BIT,
  localparam int unsigned SW   = $clog2(N_SRC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          unlock_i,
  input  logic          addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          en_o,
  output logic [SW-1:0] sel_o,
  output logic          clr_o
);
  logic wr_ctrl;
  logic          en_q;
  logic [SW-1:0] sel_q;

  assign wr_ctrl = unlock_i && we_i && !addr_i;
  assign clr_o   = unlock_i && we_i && addr_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= wdata_i[ENB];
      sel_q <= wdata_i[SW-1:0];
    end
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  p_locked_ctrl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |=> $stable(en_q) && $stable(sel_q));
  p_locked_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |-> !clr_o);
endmodule

// File: rtl/fir_pending.sv
module fir_pending
  import fast_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  localparam int unsigned SW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SW-1:0]    sel_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic [N_SRC-1:0] prev_q;
  logic             rise;
  logic             pend_q;

  assign rise = src_i[sel_i] && !prev_q[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      // set has priority over a simultaneous clear
      pend_q <= rise || (pend_q && !clr_i);
    end
  end

  assign pend_o = pend_q;

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> pend_q);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && clr_i && !rise |=> !pend_q);
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && clr_i |=> pend_q);
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !rise |=> !pend_q);
endmodule

// File: rtl/fir_node_mask.sv
module fir_node_mask
  import fast_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  localparam int unsigned SW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SW-1:0]    sel_i,
  output logic [N_SRC-1:0] node_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_node
    assign node_o[i] = src_i[i] && (sel_i != SW'(i));
  end

  always_comb begin
    p_one_masked_r6: assert ($countones(src_i & ~node_o) <= 1);
  end
endmodule

// File: rtl/fast_irq_router.sv
module fast_irq_router
  import fast_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned ENB   = EN_BIT,
  localparam int unsigned SW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             unlock_i,
  input  logic             addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             fast_irq_no,
  output logic [N_SRC-1:0] node_o
);
  logic          en;
  logic [SW-1:0] sel;
  logic          clr;
  logic          pend;

  fir_ctrl_reg #(.N_SRC(N_SRC), .DW(DW), .ENB(ENB)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlock_i(unlock_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .en_o(en), .sel_o(sel), .clr_o(clr)
  );

  fir_pending #(.N_SRC(N_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .sel_i(sel),
    .clr_i(clr), .pend_o(pend)
  );

  fir_node_mask #(.N_SRC(N_SRC)) u_mask (
    .src_i(src_i), .sel_i(sel), .node_o(node_o)
  );

  assign fast_irq_no = !(pend && en);

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[0] = pend;
    end else begin
      rdata_o[ENB]    = en;
      rdata_o[SW-1:0] = sel;
    end
  end

  p_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> fast_irq_no);
  p_sel_keeps_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && !clr |=> pend);
  p_reset_state_r8: assert property (@(posedge clk_i)
    !rst_ni |-> fast_irq_no && !pend && !en);
endmodule

// File: tb/fast_irq_router_tb_top.sv
module fast_irq_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       unlock = 1'b0;
  logic       addr = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fiq_n;
  logic [7:0] node;

  int checks = 0;
  int errors = 0;
  string tag = "R8";

  // reference model state
  bit       m_en;
  int       m_sel;
  bit       m_pend;
  bit [7:0] m_prev;

  always #2.5 clk = ~clk;

  fast_irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .unlock_i(unlock),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .fast_irq_no(fiq_n), .node_o(node)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp_v, string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  task automatic compare();
    bit [7:0] e_node;
    bit [7:0] e_rd;
    e_node = src;
    e_node[m_sel] = 1'b0;
    if (addr) e_rd = {7'b0, m_pend};
    else      e_rd = {m_en, 4'b0, 3'(m_sel)};
    chk({tag, "/R6"}, node, e_node, "node_o");
    chk({tag, "/R4"}, {7'b0, fiq_n}, {7'b0, !(m_pend && m_en)}, "fast_irq_no");
    chk({tag, "/R3"}, rdata, e_rd, "rdata_o");
  endtask

  task automatic step();
    bit rise, clr, n_pend;
    #1 compare();
    rise = src[m_sel] && !m_prev[m_sel];
    clr = unlock && we && addr && wdata[0];
    n_pend = rise || (m_pend && !clr);
    if (unlock && we && !addr) begin
      m_en = wdata[7];
      m_sel = int'(wdata[2:0]);
    end
    m_pend = n_pend;
    m_prev = src;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(bit a, bit [7:0] d);
    addr = a; we = 1'b1; wdata = d;
    step();
  endtask

  task automatic pulse(int i);
    src[i] = 1'b1; step();
    src[i] = 1'b0; step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_en = 0; m_sel = 0; m_pend = 0; m_prev = '0;
    // R8 reset state
    #1;
    compare();
    addr = 1'b1; #1 compare();
    addr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tag = "R8"; step();

    // R7 writes ignored while locked
    tag = "R7";
    wr(0, 8'h85); step();
    pulse(0);               // sel 0: pending set
    wr(1, 8'h01); step();   // locked clear ignored
    addr = 1; step();
    chk("R7", rdata, 8'h01, "pending kept");

    unlock = 1'b1;
    tag = "R2";
    wr(1, 8'h00); addr = 1; step();
    chk("R2", rdata, 8'h01, "write 0 no effect");
    wr(1, 8'h01); addr = 1; step();
    chk("R2", rdata, 8'h00, "cleared");

    // R1/R4 route source 3, enable off then on
    tag = "R1";
    wr(0, 8'h03);
    pulse(3);
    chk("R4", {7'b0, fiq_n}, 8'h01, "gated off");
    tag = "R4";
    wr(0, 8'h83);
    chk("R4", {7'b0, fiq_n}, 8'h00, "asserted");
    // R6 pass-through patterns
    tag = "R6";
    src = 8'hFF; step();
    src = 8'hA5; step();
    src = 8'h5A; step();
    src = 8'h00; step();
    // R9 reselect keeps pending
    tag = "R9";
    wr(0, 8'h86); step();
    chk("R9", {7'b0, fiq_n}, 8'h00, "pending after reselect");
    wr(1, 8'h01); step();
    // R5 set and clear together
    tag = "R5";
    src[6] = 1'b1; addr = 1; we = 1; wdata = 8'h01; step();
    src[6] = 1'b0; addr = 1; step();
    chk("R5", rdata, 8'h01, "set wins");
    wr(1, 8'h01);
    // R10 held-high source
    tag = "R10";
    src[6] = 1'b1; step(); step();
    wr(1, 8'h01); step(); step();
    addr = 1; step();
    chk("R10", rdata, 8'h00, "no re-set while held");
    src[6] = 1'b0; step();
    src[6] = 1'b1; step();
    chk("R10", rdata, 8'h01, "re-set after new edge");
    src[6] = 1'b0; wr(1, 8'h01);
    // sweep all selects
    tag = "R1";
    for (int i = 0; i < 8; i++) begin
      wr(0, 8'h80 | 8'(i));
      pulse(i);
      src = 8'hFF ^ (8'h1 << i); step();
      src = '0;
      wr(1, 8'h01);
    end
    // R7 locked again, control write ignored
    tag = "R7";
    unlock = 1'b0;
    wr(0, 8'h02); step();
    chk("R7", rdata, 8'h87, "control kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule